// File: doc/BRIEF.md
# Dual-Result Serial Capture Controller

This block is the host-side master for a dual-channel sampling converter that returns both of its 12-bit results, one after the other, on a single serial data line. One start request opens a chip-select-low window. The block generates the serial clock from the system clock and samples the line once per serial bit. It then strips the zero framing bits and splits the stream into a channel A result and a channel B result. A one-cycle done pulse marks the moment both result registers are fresh.

Each result travels in a 16-bit slot: two zero bits, twelve data bits with the most significant bit first, then two zero bits. The converter drives the first zero as soon as chip select falls and moves to the next bit on every falling serial clock edge. The controller therefore samples each bit at the end of the clock-high phase, just before the falling edge that replaces it. The first slot carries channel A and the second carries channel B. A single-channel mode stops after the first slot.

A half-period setting, in system clocks, sets the serial clock rate. A quiet-time setting holds chip select high between frames. Any framing bit that reads as one raises an error flag together with the done pulse.

Top module: `dual_capture_ctrl`

## Requirements
- R1: After reset, cs_n_o and sclk_o are 1, done_o and frame_err_o are 0, and both result registers are 0.
- R2: A start_i seen in the idle state drives cs_n_o low in the next cycle. sclk_o then stays high for exactly H cycles before its first fall, where H = max(half_i, 2).
- R3: While cs_n_o is low, every sclk_o low phase and every high phase lasts H cycles. A dual frame has exactly 32 sclk_o falling edges. cs_n_o rises at the end of the high phase that follows the 32nd fall. sclk_o is 1 whenever cs_n_o is 1.
- R4: sdata_i is sampled on the last system clock of each high phase that precedes a falling edge. Bit 0 of the stream is sampled just before the first fall.
- R5: Stream bits 2..13 (first received = bit 0) form res_a_o, MSB first. Bits 18..29 form res_b_o, MSB first.
- R6: done_o is a one-cycle pulse in the cycle in which cs_n_o returns high. Both results are valid from that cycle on.
- R7: frame_err_o is updated only together with done_o. It is 1 when any checked framing bit reads 1: stream positions 0, 1, 14 and 15, plus 16, 17, 30 and 31 in a dual frame. It holds its value until the next done.
- R8: With single_i = 1 latched at start, the frame has 16 falling edges, res_a_o is updated and res_b_o keeps its value.
- R9: After done, cs_n_o stays high for Q = max(quiet_i, 4) quiet cycles plus one idle cycle before a start can open the next frame. A start held high therefore gives a gap of Q+1 cycles.
- R10: start_i pulses while a frame or its quiet time is in progress have no effect: no extra frame and no extra done.
- R11: half_i values 0 and 1 behave as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, taken only when idle |
| half_i | input | 8 | Serial clock half-period in system clocks (min 2) |
| quiet_i | input | 8 | Chip-select high time between frames (min 4) |
| single_i | input | 1 | 1 = read only the first slot |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| res_a_o | output | 12 | Result from the first slot |
| res_b_o | output | 12 | Result from the second slot |
| done_o | output | 1 | One-cycle frame-complete pulse |
| frame_err_o | output | 1 | A framing zero read as one in the last frame |

## Verification
The bench aims at the bit boundaries. An all-ones result next to all-zero framing would show an off-by-one sampling point as a shifted value or a spurious error. A single flipped zero at stream positions 1 and 30 would go unnoticed if the error check covered the wrong positions. Half-period settings of 0 and 5 expose a missing clamp or a miscounted phase as a wrong setup length or edge count. Start pulses in the middle of a frame and during the quiet time would start a second frame on a design that fails to ignore them. A single-channel frame would overwrite the channel B register on a design that does not honour the mode.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HIGH  = 2'd1,
    SEQ_LOW   = 2'd2,
    SEQ_QUIET = 2'd3
  } seq_state_t;

  // Raise a setting to its floor value.
  function automatic int unsigned at_least(int unsigned v, int unsigned floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  // Falling edges in one frame.
  function automatic int unsigned edges_per_frame(bit single, int unsigned slot_w);
    return single ? slot_w : 2 * slot_w;
  endfunction

endpackage

// File: rtl/dcc_timer.sv
module dcc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/dcc_seq.sv
module dcc_seq
  import dcc_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int DIV_W     = 8,
  parameter int QUIET_W   = 8,
  parameter int MIN_HALF  = 2,
  parameter int MIN_QUIET = 4,
  localparam int CNT_W    = (DIV_W > QUIET_W) ? DIV_W : QUIET_W,
  localparam int EDGE_W   = $clog2(2 * SLOT_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [DIV_W-1:0]   half_i,
  input  logic [QUIET_W-1:0] quiet_i,
  input  logic               single_i,
  input  logic               expire_i,
  output logic               tmr_load_o,
  output logic [CNT_W-1:0]   tmr_val_o,
  output logic               sample_o,
  output logic               finish_o,
  output logic               single_q_o,
  output logic               cs_n_o,
  output logic               sclk_o
);

  seq_state_t         state_q;
  logic [EDGE_W-1:0]  edge_q;
  logic [EDGE_W-1:0]  edge_goal;
  logic [CNT_W-1:0]   half_q;
  logic [CNT_W-1:0]   quiet_q;
  logic               single_q;
  logic               accept;
  logic               high_end;
  logic               low_end;
  logic               quiet_end;
  logic [CNT_W-1:0]   half_new;
  logic [CNT_W-1:0]   quiet_new;

  function automatic logic [CNT_W-1:0] half_len(logic [DIV_W-1:0] d);
    return CNT_W'(at_least(32'(d), MIN_HALF) - 1);
  endfunction

  function automatic logic [CNT_W-1:0] quiet_len(logic [QUIET_W-1:0] q);
    return CNT_W'(at_least(32'(q), MIN_QUIET) - 1);
  endfunction

  assign half_new  = half_len(half_i);
  assign quiet_new = quiet_len(quiet_i);
  assign edge_goal = EDGE_W'(edges_per_frame(single_q, SLOT_W));

  // Named events
  assign accept    = (state_q == SEQ_IDLE) && start_i;
  assign high_end  = (state_q == SEQ_HIGH) && expire_i;
  assign low_end   = (state_q == SEQ_LOW) && expire_i;
  assign quiet_end = (state_q == SEQ_QUIET) && expire_i;
  assign sample_o  = high_end && (edge_q != edge_goal);
  assign finish_o  = high_end && (edge_q == edge_goal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      edge_q   <= '0;
      half_q   <= '0;
      quiet_q  <= '0;
      single_q <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (accept) begin
          state_q  <= SEQ_HIGH;
          edge_q   <= '0;
          half_q   <= half_new;
          quiet_q  <= quiet_new;
          single_q <= single_i;
        end
        SEQ_HIGH: if (finish_o) begin
          state_q <= SEQ_QUIET;
        end else if (sample_o) begin
          state_q <= SEQ_LOW;
          edge_q  <= edge_q + 1'b1;
        end
        SEQ_LOW:   if (low_end)   state_q <= SEQ_HIGH;
        SEQ_QUIET: if (quiet_end) state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_load_o = accept || high_end || low_end;
    if (accept)        tmr_val_o = half_new;
    else if (finish_o) tmr_val_o = quiet_q;
    else               tmr_val_o = half_q;
  end

  assign single_q_o = single_q;
  assign cs_n_o     = (state_q == SEQ_IDLE) || (state_q == SEQ_QUIET);
  assign sclk_o     = (state_q != SEQ_LOW);

  p_clk_idles_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  p_setup_before_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |=> (sclk_o && !cs_n_o));

  p_edge_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= edge_goal);

  p_low_min_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |=> !sclk_o);

  p_busy_keeps_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && start_i) |=> $stable(single_q));

endmodule

// File: rtl/dcc_shifter.sv
module dcc_shifter #(
  parameter int DATA_W = 12,
  parameter int SLOT_W = 16,
  localparam int FRAME_W = 2 * SLOT_W,
  localparam int GUARD   = (SLOT_W - DATA_W) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              finish_i,
  input  logic              single_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] res_a_o,
  output logic [DATA_W-1:0] res_b_o,
  output logic              done_o,
  output logic              frame_err_o
);

  logic [FRAME_W-1:0] sh_q;
  logic [SLOT_W-1:0]  slot_first;
  logic [SLOT_W-1:0]  slot_second;

  function automatic logic [DATA_W-1:0] payload(logic [SLOT_W-1:0] s);
    return s[SLOT_W-GUARD-1 -: DATA_W];
  endfunction

  function automatic logic guard_bad(logic [SLOT_W-1:0] s);
    return (|s[SLOT_W-1 -: GUARD]) || (|s[GUARD-1:0]);
  endfunction

  // Single mode: only the low half of the register has been filled.
  assign slot_first  = single_i ? sh_q[SLOT_W-1:0] : sh_q[FRAME_W-1:SLOT_W];
  assign slot_second = sh_q[SLOT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q        <= '0;
      res_a_o     <= '0;
      res_b_o     <= '0;
      done_o      <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (sample_i) sh_q <= {sh_q[FRAME_W-2:0], sdata_i};
      if (finish_i) begin
        res_a_o <= payload(slot_first);
        if (!single_i) res_b_o <= payload(slot_second);
        frame_err_o <= guard_bad(slot_first) || (!single_i && guard_bad(slot_second));
      end
    end
  end

  p_single_keeps_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && single_i) |=> $stable(res_b_o));

  p_err_moves_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_err_o) |-> done_o);

endmodule

// File: rtl/dual_capture_ctrl.sv
module dual_capture_ctrl #(
  parameter int DATA_W    = 12,
  parameter int SLOT_W    = 16,
  parameter int DIV_W     = 8,
  parameter int QUIET_W   = 8,
  parameter int MIN_HALF  = 2,
  parameter int MIN_QUIET = 4,
  localparam int CNT_W    = (DIV_W > QUIET_W) ? DIV_W : QUIET_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [DIV_W-1:0]   half_i,
  input  logic [QUIET_W-1:0] quiet_i,
  input  logic               single_i,
  input  logic               sdata_i,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic [DATA_W-1:0]  res_a_o,
  output logic [DATA_W-1:0]  res_b_o,
  output logic               done_o,
  output logic               frame_err_o
);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expire;
  logic             sample_ev;
  logic             finish_ev;
  logic             single_q;

  dcc_seq #(
    .SLOT_W(SLOT_W), .DIV_W(DIV_W), .QUIET_W(QUIET_W),
    .MIN_HALF(MIN_HALF), .MIN_QUIET(MIN_QUIET)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_i(half_i),
    .quiet_i(quiet_i), .single_i(single_i), .expire_i(tmr_expire),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .sample_o(sample_ev),
    .finish_o(finish_ev), .single_q_o(single_q), .cs_n_o(cs_n_o),
    .sclk_o(sclk_o)
  );

  dcc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .expire_o(tmr_expire)
  );

  dcc_shifter #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_ev), .finish_i(finish_ev),
    .single_i(single_q), .sdata_i(sdata_i), .res_a_o(res_a_o),
    .res_b_o(res_b_o), .done_o(done_o), .frame_err_o(frame_err_o)
  );

  p_done_at_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(cs_n_o));

  p_sample_only_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |-> (!cs_n_o && sclk_o));

endmodule

// File: tb/dual_capture_ctrl_test.sv
module dual_capture_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  half_i = 8'd2;
  logic [7:0]  quiet_i = 8'd4;
  logic        single_i = 1'b0;
  logic        sdata_i = 1'b1;
  logic        cs_n_o, sclk_o, done_o, frame_err_o;
  logic [11:0] res_a_o, res_b_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dual_capture_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_i(half_i),
    .quiet_i(quiet_i), .single_i(single_i), .sdata_i(sdata_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .res_a_o(res_a_o), .res_b_o(res_b_o),
    .done_o(done_o), .frame_err_o(frame_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp_v, $time);
    end
  endtask

  // Converter model and edge monitor
  logic [31:0] stream = '0;
  int pos = 0;
  bit prev_cs = 1'b1, prev_sclk = 1'b1;
  int falls = 0, setup_len = 0, gap = 0, last_gap = 0, dones = 0;
  bit seen_fall = 1'b0;

  always @(negedge clk) begin
    if (prev_cs && !cs_n_o) begin
      pos = 0; sdata_i <= stream[31];
      falls = 0; setup_len = 0; seen_fall = 1'b0; last_gap = gap;
    end else if (!cs_n_o && prev_sclk && !sclk_o) begin
      pos++; falls++; seen_fall = 1'b1;
      sdata_i <= (pos < 32) ? stream[31-pos] : 1'b0;
    end else if (cs_n_o) begin
      sdata_i <= 1'b1;
    end
    if (!cs_n_o && sclk_o && !seen_fall) setup_len++;
    if (cs_n_o) gap++; else gap = 0;
    if (done_o) dones++;
    prev_cs = cs_n_o; prev_sclk = sclk_o;
  end

  // Cycle reference model
  int m_st = 0, m_cnt = 0, m_edges = 0, m_nb = 0, m_half = 2, m_quiet = 4;
  bit m_single = 0;
  bit m_bits[$];
  bit e_csn = 1, e_sclk = 1, e_done = 0, e_err = 0;
  int e_a = 0, e_b = 0;

  function automatic int pick(int lo, int hi);
    int v = 0;
    for (int i = lo; i <= hi; i++) v = (v << 1) | int'(m_bits[i]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; e_csn = 1; e_sclk = 1; e_done = 0; e_err = 0; e_a = 0; e_b = 0;
    end else begin
      e_done = 0;
      case (m_st)
        0: if (start_i) begin
          m_half = (half_i < 2) ? 2 : int'(half_i);
          m_quiet = (quiet_i < 4) ? 4 : int'(quiet_i);
          m_single = single_i; m_nb = single_i ? 16 : 32;
          m_bits.delete(); m_edges = 0; m_st = 1; m_cnt = m_half;
        end
        1: begin
          m_cnt--;
          if (m_cnt == 0) begin
            if (m_edges == m_nb) begin
              e_a = pick(2, 13);
              e_err = m_bits[0] | m_bits[1] | m_bits[14] | m_bits[15];
              if (!m_single) begin
                e_b = pick(18, 29);
                e_err = e_err | m_bits[16] | m_bits[17] | m_bits[30] | m_bits[31];
              end
              e_done = 1; m_st = 3; m_cnt = m_quiet;
            end else begin
              m_bits.push_back(sdata_i); m_edges++; m_st = 2; m_cnt = m_half;
            end
          end
        end
        2: begin m_cnt--; if (m_cnt == 0) begin m_st = 1; m_cnt = m_half; end end
        default: begin m_cnt--; if (m_cnt == 0) m_st = 0; end
      endcase
      e_csn = (m_st == 0) || (m_st == 3);
      e_sclk = (m_st != 2);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check({cs_n_o, sclk_o} == {e_csn, e_sclk}, "R3/R2 pins vs model",
            {cs_n_o, sclk_o}, {e_csn, e_sclk});
      check(done_o == e_done, "R6 done vs model", done_o, e_done);
      check(res_a_o == e_a[11:0] && res_b_o == e_b[11:0], "R4/R5 results vs model",
            {res_a_o, res_b_o}, {e_a[11:0], e_b[11:0]});
      check(frame_err_o == e_err, "R7 error vs model", frame_err_o, e_err);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_frame(input logic [11:0] a, input logic [11:0] b,
                           input logic [7:0] hv, input logic [7:0] qv,
                           input bit sg, input logic [31:0] flip, input bit exp_err);
    logic [11:0] b_before;
    int h;
    b_before = res_b_o;
    h = (hv < 2) ? 2 : int'(hv);
    stream = {2'b00, a, 2'b00, 2'b00, b, 2'b00} ^ flip;
    @(negedge clk);
    half_i = hv; quiet_i = qv; single_i = sg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    check(res_a_o == a, "R5 res_a", res_a_o, a);
    if (sg) check(res_b_o == b_before, "R8 res_b kept", res_b_o, b_before);
    else    check(res_b_o == b, "R5 res_b", res_b_o, b);
    check(falls == (sg ? 16 : 32), sg ? "R8 edge count" : "R3 edge count",
          falls, sg ? 16 : 32);
    check(setup_len == h, "R2/R11 setup length", setup_len, h);
    check(frame_err_o == exp_err, "R7 error flag", frame_err_o, exp_err);
    check(cs_n_o == 1'b1, "R6 cs high at done", cs_n_o, 1);
    @(negedge clk);
    check(done_o == 1'b0, "R6 one-cycle pulse", done_o, 0);
    repeat ((qv < 4 ? 4 : qv) + 3) @(negedge clk);
  endtask

  initial begin
    int d0;
    int q;
    repeat (3) @(negedge clk);
    check(cs_n_o && sclk_o, "R1 reset pins", {cs_n_o, sclk_o}, 3);
    check(!done_o && !frame_err_o && res_a_o == 0 && res_b_o == 0,
          "R1 reset outputs", {done_o, frame_err_o, res_a_o, res_b_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_frame(12'hABC, 12'h123, 8'd2, 8'd4, 1'b0, 32'h0, 1'b0);
    run_frame(12'hFFF, 12'h000, 8'd5, 8'd6, 1'b0, 32'h0, 1'b0);
    run_frame(12'h000, 12'hFFF, 8'd0, 8'd1, 1'b0, 32'h0, 1'b0);   // R11 clamp
    run_frame(12'h5A5, 12'hA5A, 8'd1, 8'd4, 1'b0, 32'h0, 1'b0);
    // R7: flip stream position 1 (bit 30 of the 32-bit word)
    run_frame(12'h0F0, 12'h00F, 8'd3, 8'd4, 1'b0, 32'h4000_0000, 1'b1);
    run_frame(12'h0F0, 12'h00F, 8'd3, 8'd4, 1'b0, 32'h0, 1'b0);
    // R7: flip stream position 30 (bit 1 of the word)
    run_frame(12'h321, 12'h654, 8'd2, 8'd4, 1'b0, 32'h0000_0002, 1'b1);
    // R8: single mode, channel B register keeps 654
    run_frame(12'h9C3, 12'h111, 8'd2, 8'd4, 1'b1, 32'h0, 1'b0);
    // R8/R7: single mode ignores second slot framing bits
    run_frame(12'h777, 12'h222, 8'd2, 8'd4, 1'b1, 32'h0000_0001, 1'b0);

    // R10: start pulses inside a frame and inside the quiet time
    stream = {2'b00, 12'h468, 2'b00, 2'b00, 12'hACE, 2'b00};
    d0 = dones;
    @(negedge clk); half_i = 8'd2; quiet_i = 8'd8; single_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (30) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (40) @(negedge clk);
    check(dones - d0 == 1, "R10 one done only", dones - d0, 1);
    check(cs_n_o == 1'b1, "R10 no extra frame", cs_n_o, 1);
    check(res_b_o == 12'hACE, "R10 result intact", res_b_o, 12'hACE);

    // R9: start held high, gap between frames is Q+1
    q = 6;
    @(negedge clk); half_i = 8'd2; quiet_i = 8'(q); start_i = 1'b1;
    while (!done_o) @(negedge clk);
    while (cs_n_o) @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check(last_gap == q + 1, "R9 quiet gap", last_gap, q + 1);
    while (!done_o) @(negedge clk);
    repeat (12) @(negedge clk);
    q = 2;
    @(negedge clk); quiet_i = 8'(q); start_i = 1'b1;
    while (!done_o) @(negedge clk);
    while (cs_n_o) @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check(last_gap == 5, "R9 quiet floor", last_gap, 5);
    while (!done_o) @(negedge clk);
    repeat (12) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule